// File: doc/BRIEF.md
# Power-Management Interrupt Event Combiner

This block decides the level of the system control interrupt of a power-management function. It holds two banks of event registers. The first is a 16-bit fixed-event status register with a matching 16-bit enable register. The second is a general-purpose event status register with a matching enable register; it is a parameterised number of bytes wide and two bytes by default. Event sources raise status bits with one-cycle set strobes. Software clears a status bit by writing 1 to it and programs the enables through a byte-lane write port. The interrupt output is a level. It stays high while any enabled status bit that is allowed to interrupt is set.

Only four fixed-event sources may raise the interrupt: the timer, the global lock, the power button and the real-time clock. In the general-purpose bank, only two bits of byte 0 may raise it: the PCI-hotplug bit and the CPU-hotplug bit. A second output tells an external free-running timer to arm its overflow wakeup. It is high while the timer event is enabled and its status bit is still clear. Both outputs come from registers and are re-evaluated on every clock, so every register write and every status change is reflected in them.

Top module: `pm_sci_combiner`

## Requirements
- R1: A synchronous active-high reset clears all status and enable bits; `sci_o` and `tmr_arm_o` are low on the cycle after reset is sampled.
- R2: The fixed bank asserts the interrupt only from bit positions 0 (timer), 5 (global lock), 8 (power button) and 10 (real-time clock), each only when the same bit is set in both status and enable; every other fixed-bank bit never affects `sci_o`.
- R3: The general-purpose bank asserts the interrupt only from byte 0 bit 1 (PCI hotplug, 0x02) and byte 0 bit 2 (CPU hotplug, 0x04), each when set in both status and enable; other general-purpose bits, including all of byte 1, never affect `sci_o`.
- R4: `sci_o` is the OR of the two bank contributions and is a level: it stays high for as long as a qualifying status/enable pair stays set, and falls once either the status or the enable is cleared.
- R5: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R6: A set strobe and a write-1-to-clear that hit the same status bit in the same cycle leave the bit set.
- R7: `tmr_arm_o` is high exactly when the timer enable (fixed bank bit 0) is set and the timer status (fixed bank bit 0) is clear.
- R8: The write port is little-endian with byte lanes. Lane i writes the register byte at offset `wr_addr_i + i`. The byte offsets are: 0 and 1 for fixed status, 2 and 3 for fixed enable, 4 and 5 for general-purpose status, and 6 and 7 for general-purpose enable (low byte first). Accesses of 1 to 4 bytes may start at any offset.
- R9: A lane whose offset falls outside offsets 0 to 7 is ignored.
- R10: Both outputs follow the register state with one cycle of delay. A set strobe or write sampled at clock edge k changes the registers at edge k, and the outputs change at edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm1_set_i | input | 16 | One-cycle set strobes for fixed-bank status bits |
| gpe_set_i | input | 8*GPE_BYTES | One-cycle set strobes for general-purpose status bits |
| wr_be_i | input | LANES | Byte-lane write enables; any set bit is a write |
| wr_addr_i | input | ADDR_W | Register byte offset of lane 0 |
| wr_data_i | input | 8*LANES | Write data, lane i in bits 8i+7..8i |
| sci_o | output | 1 | Registered interrupt level |
| tmr_arm_o | output | 1 | Registered request to arm the timer overflow wakeup |

## Verification
The bench builds the block with four byte lanes, a 4-bit offset and a two-byte general-purpose bank, which are the defaults. With these values the register map fills offsets 0 to 7 of a 16-offset space. A four-lane write at offset 6 therefore spills two lanes onto unmapped offsets, and a write at offset 1 straddles the boundary between the status and enable registers. A two-byte general-purpose bank gives the bench a byte 1 to prove harmless. A cycle-accurate model in the bench is compared with both outputs on every clock, through directed sequences and a long stretch of random strobes and writes.

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;
  localparam int unsigned PM1_W      = 16;
  localparam int unsigned PM1_BYTES  = PM1_W / 8;
  localparam int unsigned TMR_BIT    = 0;
  localparam int unsigned GLOCK_BIT  = 5;
  localparam int unsigned PWRBTN_BIT = 8;
  localparam int unsigned RTC_BIT    = 10;
  localparam logic [PM1_W-1:0] PM1_SCI_MASK =
    (PM1_W'(1) << TMR_BIT) | (PM1_W'(1) << GLOCK_BIT) |
    (PM1_W'(1) << PWRBTN_BIT) | (PM1_W'(1) << RTC_BIT);

  localparam int unsigned GPE_PCI_BIT = 1;
  localparam int unsigned GPE_CPU_BIT = 2;
  localparam logic [7:0] GPE_SCI_MASK =
    (8'(1) << GPE_PCI_BIT) | (8'(1) << GPE_CPU_BIT);

  // byte offsets of the register map
  localparam int unsigned OFS_PM1_STS = 0;
  localparam int unsigned OFS_PM1_EN  = OFS_PM1_STS + PM1_BYTES;
  localparam int unsigned OFS_GPE     = OFS_PM1_EN + PM1_BYTES;
endpackage

// File: rtl/pm_wr_lane_map.sv
module pm_wr_lane_map #(
  parameter int unsigned LANES     = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned MAP_BYTES = 8
) (
  input  logic [LANES-1:0]       be_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [8*LANES-1:0]     data_i,
  output logic [MAP_BYTES-1:0]   stb_o,
  output logic [8*MAP_BYTES-1:0] dat_o
);
  // each register byte looks for the lane that lands on it
  for (genvar j = 0; j < MAP_BYTES; j++) begin : g_byte
    always_comb begin
      stb_o[j]       = 1'b0;
      dat_o[8*j +: 8] = 8'h00;
      for (int i = 0; i < LANES; i++) begin
        if (be_i[i] && ((int'(addr_i) + i) == j)) begin
          stb_o[j]        = 1'b1;
          dat_o[8*j +: 8] = data_i[8*i +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/pm_evt_bank.sv
module pm_evt_bank #(
  parameter int unsigned BYTES = 2,
  localparam int unsigned W    = 8 * BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     set_i,
  input  logic [BYTES-1:0] sts_stb_i,
  input  logic [W-1:0]     sts_dat_i,
  input  logic [BYTES-1:0] en_stb_i,
  input  logic [W-1:0]     en_dat_i,
  output logic [W-1:0]     sts_o,
  output logic [W-1:0]     en_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [7:0] sts_q;
    logic [7:0] en_q;
    logic [7:0] clr;

    assign clr = sts_stb_i[b] ? sts_dat_i[8*b +: 8] : 8'h00;

    always_ff @(posedge clk) begin
      if (rst) begin
        sts_q <= 8'h00;
        en_q  <= 8'h00;
      end else begin
        // set strobe beats write-1-to-clear
        sts_q <= (sts_q & ~clr) | set_i[8*b +: 8];
        if (en_stb_i[b]) en_q <= en_dat_i[8*b +: 8];
      end
    end

    assign sts_o[8*b +: 8] = sts_q;
    assign en_o[8*b +: 8]  = en_q;
  end
endmodule

// File: rtl/pm_sci_reduce.sv
module pm_sci_reduce
  import pm_sci_pkg::*;
#(
  parameter int unsigned GPE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PM1_W-1:0] pm1_sts_i,
  input  logic [PM1_W-1:0] pm1_en_i,
  input  logic [GPE_W-1:0] gpe_sts_i,
  input  logic [GPE_W-1:0] gpe_en_i,
  output logic             sci_o,
  output logic             tmr_arm_o
);
  logic pm1_hit;
  logic gpe_hit;
  logic arm_d;

  assign pm1_hit = |(pm1_sts_i & pm1_en_i & PM1_SCI_MASK);
  assign gpe_hit = |(gpe_sts_i[7:0] & gpe_en_i[7:0] & GPE_SCI_MASK);
  assign arm_d   = pm1_en_i[TMR_BIT] & ~pm1_sts_i[TMR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_o     <= 1'b0;
      tmr_arm_o <= 1'b0;
    end else begin
      sci_o     <= pm1_hit | gpe_hit;
      tmr_arm_o <= arm_d;
    end
  end
endmodule

// File: rtl/pm_sci_combiner.sv
module pm_sci_combiner
  import pm_sci_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned GPE_BYTES = 2,
  localparam int unsigned GPE_W     = 8 * GPE_BYTES,
  localparam int unsigned MAP_BYTES = OFS_GPE + 2 * GPE_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PM1_W-1:0]   pm1_set_i,
  input  logic [GPE_W-1:0]   gpe_set_i,
  input  logic [LANES-1:0]   wr_be_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [8*LANES-1:0] wr_data_i,
  output logic               sci_o,
  output logic               tmr_arm_o
);
  localparam int unsigned OFS_GPE_EN = OFS_GPE + GPE_BYTES;

  logic [MAP_BYTES-1:0]   byte_stb;
  logic [8*MAP_BYTES-1:0] byte_dat;
  logic [PM1_W-1:0]       pm1_sts;
  logic [PM1_W-1:0]       pm1_en;
  logic [GPE_W-1:0]       gpe_sts;
  logic [GPE_W-1:0]       gpe_en;

  pm_wr_lane_map #(
    .LANES(LANES), .ADDR_W(ADDR_W), .MAP_BYTES(MAP_BYTES)
  ) u_map (
    .be_i(wr_be_i), .addr_i(wr_addr_i), .data_i(wr_data_i),
    .stb_o(byte_stb), .dat_o(byte_dat)
  );

  pm_evt_bank #(.BYTES(PM1_BYTES)) u_pm1 (
    .clk(clk), .rst(rst), .set_i(pm1_set_i),
    .sts_stb_i(byte_stb[OFS_PM1_STS +: PM1_BYTES]),
    .sts_dat_i(byte_dat[8*OFS_PM1_STS +: PM1_W]),
    .en_stb_i(byte_stb[OFS_PM1_EN +: PM1_BYTES]),
    .en_dat_i(byte_dat[8*OFS_PM1_EN +: PM1_W]),
    .sts_o(pm1_sts), .en_o(pm1_en)
  );

  pm_evt_bank #(.BYTES(GPE_BYTES)) u_gpe (
    .clk(clk), .rst(rst), .set_i(gpe_set_i),
    .sts_stb_i(byte_stb[OFS_GPE +: GPE_BYTES]),
    .sts_dat_i(byte_dat[8*OFS_GPE +: GPE_W]),
    .en_stb_i(byte_stb[OFS_GPE_EN +: GPE_BYTES]),
    .en_dat_i(byte_dat[8*OFS_GPE_EN +: GPE_W]),
    .sts_o(gpe_sts), .en_o(gpe_en)
  );

  pm_sci_reduce #(.GPE_W(GPE_W)) u_reduce (
    .clk(clk), .rst(rst),
    .pm1_sts_i(pm1_sts), .pm1_en_i(pm1_en),
    .gpe_sts_i(gpe_sts), .gpe_en_i(gpe_en),
    .sci_o(sci_o), .tmr_arm_o(tmr_arm_o)
  );
endmodule

// File: rtl/pm_sci_checker.sv
module pm_sci_checker
  import pm_sci_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned GPE_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [PM1_W-1:0] pm1_set,
  input logic [LANES-1:0] wr_be,
  input logic [PM1_W-1:0] pm1_sts,
  input logic [PM1_W-1:0] pm1_en,
  input logic [GPE_W-1:0] gpe_sts,
  input logic [GPE_W-1:0] gpe_en,
  input logic             sci,
  input logic             tmr_arm
);
  // R1: reset empties the banks and silences both outputs
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!sci && !tmr_arm && pm1_sts == '0 && gpe_sts == '0));

  // R4 (with R2, R3): no qualifying pair in the previous cycle means no interrupt
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
    ($past((pm1_sts & pm1_en & 16'h0521) == '0) &&
     $past((gpe_sts[7:0] & gpe_en[7:0] & 8'h06) == '0)) |-> !sci);

  // R5: a timer status bit only drops after a write or a reset
  p_w1c_only_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(pm1_sts[TMR_BIT]) |-> $past((|wr_be) | rst));

  // R6: a set strobe always lands, whatever is written alongside it
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    pm1_set[TMR_BIT] |=> pm1_sts[TMR_BIT]);

  // R7: a pending timer status withdraws the arm request one cycle later
  p_arm_drop_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pm1_sts[TMR_BIT]) |=> !tmr_arm);
endmodule

bind pm_sci_combiner pm_sci_checker #(.LANES(LANES), .GPE_W(GPE_W)) u_chk (
  .clk(clk), .rst(rst), .pm1_set(pm1_set_i), .wr_be(wr_be_i),
  .pm1_sts(pm1_sts), .pm1_en(pm1_en), .gpe_sts(gpe_sts), .gpe_en(gpe_en),
  .sci(sci_o), .tmr_arm(tmr_arm_o)
);

// File: tb/pm_sci_combiner_tb_top.sv
`timescale 1ns/1ps
module pm_sci_combiner_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pm1_set = '0;
  logic [15:0] gpe_set = '0;
  logic [3:0]  wr_be = '0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        sci;
  logic        tmr_arm;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  pm_sci_combiner #(.LANES(4), .ADDR_W(4), .GPE_BYTES(2)) dut_i (
    .clk(clk), .rst(rst), .pm1_set_i(pm1_set), .gpe_set_i(gpe_set),
    .wr_be_i(wr_be), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sci_o(sci), .tmr_arm_o(tmr_arm)
  );

  // behavioural reference: register bytes by offset, outputs one edge late
  logic [7:0] m_reg [8];
  logic       exp_sci = 1'b0;
  logic       exp_arm = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_reg[k]) m_reg[k] = 8'h00;
      exp_sci = 1'b0;
      exp_arm = 1'b0;
    end else begin
      exp_sci = ((m_reg[0] & m_reg[2] & 8'h21) != 0) ||
                ((m_reg[1] & m_reg[3] & 8'h05) != 0) ||
                ((m_reg[4] & m_reg[6] & 8'h06) != 0);
      exp_arm = m_reg[2][0] && !m_reg[0][0];
      for (int i = 0; i < 4; i++) begin
        int a;
        a = int'(wr_addr) + i;
        if (wr_be[i] && a < 8) begin
          if (a == 0 || a == 1 || a == 4 || a == 5)
            m_reg[a] = m_reg[a] & ~wr_data[8*i +: 8];
          else
            m_reg[a] = wr_data[8*i +: 8];
        end
      end
      m_reg[0] = m_reg[0] | pm1_set[7:0];
      m_reg[1] = m_reg[1] | pm1_set[15:8];
      m_reg[4] = m_reg[4] | gpe_set[7:0];
      m_reg[5] = m_reg[5] | gpe_set[15:8];
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (sci !== exp_sci || tmr_arm !== exp_arm) begin
        n_err++;
        $display("FAIL %s model: sci=%b arm=%b expected sci=%b arm=%b",
                 cur_req, sci, tmr_arm, exp_sci, exp_arm);
      end
    end
  end

  task automatic lit(input string tag, input logic e_sci, input logic e_arm);
    n_chk++;
    if (sci !== e_sci || tmr_arm !== e_arm) begin
      n_err++;
      $display("FAIL %s direct: sci=%b arm=%b expected sci=%b arm=%b",
               tag, sci, tmr_arm, e_sci, e_arm);
    end
  endtask

  // one active cycle, then inputs return to idle
  task automatic drive(input int a, input logic [3:0] be, input logic [31:0] d,
                       input logic [15:0] ps, input logic [15:0] gs);
    @(negedge clk);
    wr_addr = 4'(a); wr_be = be; wr_data = d; pm1_set = ps; gpe_set = gs;
    @(negedge clk);
    wr_be = '0; wr_data = '0; pm1_set = '0; gpe_set = '0;
  endtask

  task automatic settle_chk(input string tag, input logic e_sci, input logic e_arm);
    @(negedge clk);
    #0.5 lit(tag, e_sci, e_arm);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #0.5 lit("R1", 1'b0, 1'b0);
    rst = 1'b0;

    cur_req = "R7";
    drive(2, 4'b0001, 32'h01, '0, '0);            // timer enable
    settle_chk("R7", 1'b0, 1'b1);

    cur_req = "R2";
    drive(0, 4'b0000, '0, 16'h0001, '0);          // timer status set
    settle_chk("R2", 1'b1, 1'b0);

    cur_req = "R5";
    drive(0, 4'b0001, 32'h00, '0, '0);            // write 0: no effect
    settle_chk("R5", 1'b1, 1'b0);
    drive(0, 4'b0001, 32'h01, '0, '0);            // write 1: clear
    settle_chk("R5", 1'b0, 1'b1);

    cur_req = "R2";
    drive(2, 4'b0001, 32'h03, 16'h0002, '0);      // bit 1 pending and enabled
    settle_chk("R2", 1'b0, 1'b1);
    cur_req = "R8";
    drive(0, 4'b1100, 32'h0521_0000, '0, '0);     // lanes 2,3 -> enables
    drive(0, 4'b0000, '0, 16'h0100, '0);          // power button
    settle_chk("R8", 1'b1, 1'b1);
    drive(1, 4'b0001, 32'h01, '0, '0);            // clear bit 8 via byte 1
    settle_chk("R5", 1'b0, 1'b1);
    drive(0, 4'b0000, '0, 16'h0420, '0);          // rtc + global lock
    settle_chk("R2", 1'b1, 1'b1);
    drive(1, 4'b0011, 32'h0000_0004, '0, '0);     // straddle: clr rtc, en lo=0
    settle_chk("R8", 1'b0, 1'b0);
    drive(0, 4'b0001, 32'h20, '0, '0);            // drop global lock status
    settle_chk("R5", 1'b0, 1'b0);

    cur_req = "R3";
    drive(6, 4'b0011, 32'hFFFF, '0, 16'hFF01);    // all enabled; bit0 + byte1
    settle_chk("R3", 1'b0, 1'b0);
    drive(4, 4'b0000, '0, '0, 16'h0002);          // pci hotplug
    settle_chk("R3", 1'b1, 1'b0);
    drive(4, 4'b0001, 32'h02, '0, '0);
    settle_chk("R3", 1'b0, 1'b0);
    drive(4, 4'b0000, '0, '0, 16'h0004);          // cpu hotplug
    cur_req = "R4";
    repeat (3) settle_chk("R4", 1'b1, 1'b0);      // level holds

    cur_req = "R9";
    drive(6, 4'b1100, 32'hFFFF_0000, '0, '0);     // lanes at 8,9: ignored
    settle_chk("R9", 1'b1, 1'b0);
    drive(15, 4'b1111, 32'hFFFF_FFFF, '0, '0);    // lane 0 at 15 only hits map via none
    settle_chk("R9", 1'b1, 1'b0);

    cur_req = "R6";
    drive(4, 4'b0001, 32'h04, '0, 16'h0004);      // set and clear same bit
    settle_chk("R6", 1'b1, 1'b0);
    cur_req = "R4";
    drive(6, 4'b0001, 32'h00, '0, '0);            // disable -> level falls
    settle_chk("R4", 1'b0, 1'b0);

    cur_req = "R10";
    drive(3, 4'b0001, 32'h04, '0, '0);            // enable rtc
    drive(0, 4'b0000, '0, 16'h0400, '0);
    #0.5 lit("R10", 1'b0, 1'b0);                  // registers moved, output not yet
    settle_chk("R10", 1'b1, 1'b0);

    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #0.5 lit("R1", 1'b0, 1'b0);

    cur_req = "R2";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      pm1_set = 16'($urandom) & 16'($urandom) & 16'($urandom);
      gpe_set = 16'($urandom) & 16'($urandom);
      wr_be   = 4'($urandom);
      wr_addr = 4'($urandom_range(0, 9));
      wr_data = $urandom;
    end
    @(negedge clk);
    wr_be = '0; pm1_set = '0; gpe_set = '0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    done = 1;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule